// File: doc/BRIEF.md
# VGA Raster Sync Timing Generator

This block walks a 640x480, 60 Hz raster one pixel at a time. It advances only on cycles where a pixel-clock enable is high, so it can run from a faster system clock. From the raster position it drives both sync outputs, a flag that marks the visible region, and the current pixel and line counts. Other logic reads these counts to find its place on the screen.

Two strobes mark fixed points in the raster. The line-start strobe fires when horizontal sync returns high. A downstream line fetcher that starts there sees back porch, then the visible pixels, then front porch, and the sync pulse last. The frame-start strobe fires when the raster wraps back to the top-left visible pixel. Every interval in the raster is a parameter. The defaults give the standard 800-clock line and 525-line frame, which at a 25.175 MHz pixel rate comes to about 31.4 kHz and 60 Hz.

Top module: `vga_sync_gen`

## Requirements
- R1: The pixel counter advances by one on each clock with pixEn high and goes from H_TOTAL-1 (799 by default) back to 0.
- R2: The line counter advances by one each time the pixel counter wraps and goes from V_TOTAL-1 (524 by default) back to 0. It changes at no other time.
- R3: hSyncN is low exactly while the pixel counter is in the sync window and high otherwise. By default the window is counts 656 to 751: 640 visible pixels, then 16 front porch, then 96 sync, then 48 back porch.
- R4: On blanking lines (line count 480 or more by default), hSyncN keeps the same low pulse on every line as on visible lines.
- R5: vSyncN is low exactly while the line counter is 490 or 491 (two lines after 480 visible lines and a 10-line front porch) and high otherwise. The 33-line back porch follows.
- R6: active is high exactly when the pixel counter is below 640 and the line counter is below 480.
- R7: lineStart is high for one clock, in the clock where the pixel counter has just become 752, which is the first count with hSyncN high again. From that point there are 48 back-porch counts before the counter reaches 0.
- R8: frameStart is high for one clock, in the clock after the counters wrap together to line 0, pixel 0. A reset does not raise it.
- R9: A synchronous reset sets both counters to 0, both syncs high, active high and both strobes low.
- R10: While pixEn is low, the counters and all outputs hold their values, and both strobes are low.
- R11: With the default parameters, lineStart pulses repeat every 800 enabled clocks and the line counter steps once per 800 enabled clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Pixel-clock enable; the raster advances one pixel per enabled clock |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| active | output | 1 | High inside the visible region |
| lineStart | output | 1 | One-clock strobe at the end of the horizontal sync pulse |
| frameStart | output | 1 | One-clock strobe at the wrap to line 0, pixel 0 |
| hCount | output | HCNT_W | Current pixel position in the line |
| vCount | output | VCNT_W | Current line position in the frame |

## Verification
The bench builds two instances. The first shrinks every interval to a few pixels or lines: a 17-pixel line of 8/2/3/4 and an 11-line frame of 5/1/2/3. Under a random enable, this brings dozens of full frames, every vertical wrap, frame strobes and a mid-frame reset within a few thousand clocks. The second keeps the default 640x480 timing and runs just over two lines with the enable held high. It confirms the real 656/752/800 pixel boundaries and the line step.

// File: rtl/vga_timing_pkg.sv
package vga_timing_pkg;

  // Strobes the sequencing logic hands to the counter datapath each clock.
  typedef struct packed {
    logic advance;   // move one pixel this clock
    logic hWrap;     // pixel counter is at its last count and advancing
    logic vWrap;     // line counter is also at its last count
  } rasterStep_t;

  // True when pos lies in [lo, lo+len).
  function automatic logic inWindow(input int unsigned pos,
                                    input int unsigned lo,
                                    input int unsigned len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import vga_timing_pkg::*;
#(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  parameter int HCNT_W  = $clog2(H_TOTAL),
  parameter int VCNT_W  = $clog2(V_TOTAL)
) (
  input  logic              pixEn,
  input  logic [HCNT_W-1:0] hCount,
  input  logic [VCNT_W-1:0] vCount,
  output rasterStep_t       step
);

  localparam logic [HCNT_W-1:0] H_LAST = HCNT_W'(H_TOTAL - 1);
  localparam logic [VCNT_W-1:0] V_LAST = VCNT_W'(V_TOTAL - 1);

  logic atLineEnd;
  logic atFrameEnd;

  assign atLineEnd  = (hCount == H_LAST);
  assign atFrameEnd = (vCount == V_LAST);

  always_comb begin
    step.advance = pixEn;
    step.hWrap   = pixEn && atLineEnd;
    step.vWrap   = pixEn && atLineEnd && atFrameEnd;
  end

endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import vga_timing_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int HCNT_W   = 10,
  parameter int VCNT_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  rasterStep_t       step,
  output logic [HCNT_W-1:0] hCount,
  output logic [VCNT_W-1:0] vCount,
  output logic              hSyncN,
  output logic              vSyncN,
  output logic              active,
  output logic              lineStart,
  output logic              frameStart
);

  localparam int H_SYNC_START = H_ACTIVE + H_FRONT;
  localparam int V_SYNC_START = V_ACTIVE + V_FRONT;
  localparam logic [HCNT_W-1:0] H_SYNC_END = HCNT_W'(H_SYNC_START + H_SYNC);

  logic [HCNT_W-1:0] hNext;
  logic [VCNT_W-1:0] vNext;

  always_comb begin
    hNext = step.hWrap ? '0 : hCount + HCNT_W'(1);
    if (step.vWrap)      vNext = '0;
    else if (step.hWrap) vNext = vCount + VCNT_W'(1);
    else                 vNext = vCount;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount     <= '0;
      vCount     <= '0;
      hSyncN     <= 1'b1;
      vSyncN     <= 1'b1;
      active     <= 1'b1;
      lineStart  <= 1'b0;
      frameStart <= 1'b0;
    end else if (step.advance) begin
      hCount     <= hNext;
      vCount     <= vNext;
      hSyncN     <= !inWindow(int'(hNext), H_SYNC_START, H_SYNC);
      vSyncN     <= !inWindow(int'(vNext), V_SYNC_START, V_SYNC);
      active     <= (int'(hNext) < H_ACTIVE) && (int'(vNext) < V_ACTIVE);
      lineStart  <= (hNext == H_SYNC_END);
      frameStart <= step.vWrap;
    end else begin
      lineStart  <= 1'b0;
      frameStart <= 1'b0;
    end
  end

endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen
  import vga_timing_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  parameter int HCNT_W   = $clog2(H_ACTIVE + H_FRONT + H_SYNC + H_BACK),
  parameter int VCNT_W   = $clog2(V_ACTIVE + V_FRONT + V_SYNC + V_BACK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pixEn,
  output logic              hSyncN,
  output logic              vSyncN,
  output logic              active,
  output logic              lineStart,
  output logic              frameStart,
  output logic [HCNT_W-1:0] hCount,
  output logic [VCNT_W-1:0] vCount
);

  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;

  rasterStep_t step;

  raster_ctrl #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
    .HCNT_W(HCNT_W), .VCNT_W(VCNT_W)
  ) ctrl_i (
    .pixEn (pixEn),
    .hCount(hCount),
    .vCount(vCount),
    .step  (step)
  );

  raster_datapath #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC),
    .HCNT_W(HCNT_W), .VCNT_W(VCNT_W)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .hCount    (hCount),
    .vCount    (vCount),
    .hSyncN    (hSyncN),
    .vSyncN    (vSyncN),
    .active    (active),
    .lineStart (lineStart),
    .frameStart(frameStart)
  );

endmodule

// File: rtl/vga_sync_gen_chk.sv
module vga_sync_gen_chk #(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  parameter int HCNT_W   = 10,
  parameter int VCNT_W   = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              pixEn,
  input logic              hSyncN,
  input logic              vSyncN,
  input logic              active,
  input logic              lineStart,
  input logic              frameStart,
  input logic [HCNT_W-1:0] hCount,
  input logic [VCNT_W-1:0] vCount
);

  localparam int HT  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int VT  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HSS = H_ACTIVE + H_FRONT;
  localparam int VSS = V_ACTIVE + V_FRONT;

  p_hstep_r1: assert property (@(posedge clk) disable iff (rst)
    pixEn && int'(hCount) != HT - 1 |=> int'(hCount) == int'($past(hCount)) + 1);

  p_hwrap_r1: assert property (@(posedge clk) disable iff (rst)
    pixEn && int'(hCount) == HT - 1 |=> hCount == '0);

  p_vstep_r2: assert property (@(posedge clk) disable iff (rst)
    pixEn && int'(hCount) == HT - 1 && int'(vCount) != VT - 1
    |=> int'(vCount) == int'($past(vCount)) + 1);

  p_vhold_r2: assert property (@(posedge clk) disable iff (rst)
    int'(hCount) != HT - 1 |=> $stable(vCount));

  p_hsync_r3: assert property (@(posedge clk) disable iff (rst)
    hSyncN == !(int'(hCount) >= HSS && int'(hCount) < HSS + H_SYNC));

  p_vsync_r5: assert property (@(posedge clk) disable iff (rst)
    vSyncN == !(int'(vCount) >= VSS && int'(vCount) < VSS + V_SYNC));

  p_active_r6: assert property (@(posedge clk) disable iff (rst)
    active == (int'(hCount) < H_ACTIVE && int'(vCount) < V_ACTIVE));

  p_linestart_r7: assert property (@(posedge clk) disable iff (rst)
    lineStart |-> int'(hCount) == HSS + H_SYNC && $rose(hSyncN));

  p_linestart_once_r7: assert property (@(posedge clk) disable iff (rst)
    lineStart |=> !lineStart);

  p_framestart_r8: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> hCount == '0 && vCount == '0 && int'($past(vCount)) == VT - 1);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> $stable(hCount) && $stable(vCount) && $stable(hSyncN)
               && !lineStart && !frameStart);

endmodule

bind vga_sync_gen vga_sync_gen_chk #(
  .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
  .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
  .HCNT_W(HCNT_W), .VCNT_W(VCNT_W)
) chk_i (
  .clk(clk), .rst(rst), .pixEn(pixEn), .hSyncN(hSyncN), .vSyncN(vSyncN),
  .active(active), .lineStart(lineStart), .frameStart(frameStart),
  .hCount(hCount), .vCount(vCount)
);

// File: tb/vga_sync_gen_tb_top.sv
module vga_sync_gen_tb_top;

  // Shrunken raster for the randomised instance.
  localparam int SHA = 8, SHF = 2, SHS = 3, SHB = 4;
  localparam int SVA = 5, SVF = 1, SVS = 2, SVB = 3;
  localparam int SHT = SHA + SHF + SHS + SHB;
  localparam int SVT = SVA + SVF + SVS + SVB;
  localparam int SHW = $clog2(SHT);
  localparam int SVW = $clog2(SVT);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pixEn = 1'b0;
  logic fullEn = 1'b0;
  always #10 clk = !clk;

  logic sHs, sVs, sAct, sLs, sFs;
  logic [SHW-1:0] sH;
  logic [SVW-1:0] sV;
  logic fHs, fVs, fAct, fLs, fFs;
  logic [9:0] fH, fV;

  vga_sync_gen #(
    .H_ACTIVE(SHA), .H_FRONT(SHF), .H_SYNC(SHS), .H_BACK(SHB),
    .V_ACTIVE(SVA), .V_FRONT(SVF), .V_SYNC(SVS), .V_BACK(SVB)
  ) dut_i (
    .clk(clk), .rst(rst), .pixEn(pixEn), .hSyncN(sHs), .vSyncN(sVs),
    .active(sAct), .lineStart(sLs), .frameStart(sFs), .hCount(sH), .vCount(sV)
  );

  vga_sync_gen dutFull_i (
    .clk(clk), .rst(rst), .pixEn(fullEn), .hSyncN(fHs), .vSyncN(fVs),
    .active(fAct), .lineStart(fLs), .frameStart(fFs), .hCount(fH), .vCount(fV)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit inWin(input int p, input int lo, input int len);
    return p >= lo && p < lo + len;
  endfunction

  // Reference model state for the small raster.
  int eh, ev;
  bit eLs, eFs;

  task automatic modelStep();
    eLs = 0; eFs = 0;
    if (eh == SHT - 1) begin
      eh = 0;
      if (ev == SVT - 1) begin ev = 0; eFs = 1; end
      else ev = ev + 1;
    end else eh = eh + 1;
    if (eh == SHA + SHF + SHS) eLs = 1;
  endtask

  task automatic compareSmall(input bit wasEn);
    string rh;
    rh = (ev >= SVA) ? "R4" : "R3";
    check(wasEn ? "R1" : "R10", sH, eh);
    check(wasEn ? "R2" : "R10", sV, ev);
    check(rh, sHs, !inWin(eh, SHA + SHF, SHS));
    check("R5", sVs, !inWin(ev, SVA + SVF, SVS));
    check("R6", sAct, (eh < SHA) && (ev < SVA));
    check(wasEn ? "R7" : "R10", sLs, eLs);
    check(wasEn ? "R8" : "R10", sFs, eFs);
  endtask

  initial begin
    bit prevEn;
    int frames;
    void'($urandom(32'd20240611));
    eh = 0; ev = 0; eLs = 0; eFs = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state on both instances
    check("R9", sH, 0); check("R9", sV, 0);
    check("R9", sHs, 1); check("R9", sVs, 1);
    check("R9", sAct, 1); check("R9", sLs, 0); check("R9", sFs, 0);
    check("R9", fH, 0); check("R9", fHs, 1); check("R9", fVs, 1);
    rst = 1'b0;
    prevEn = 0;
    frames = 0;
    for (int i = 0; i < 6000; i++) begin
      bit resetNow;
      resetNow = (i == 3001);
      if (i > 0) @(negedge clk);
      if (rst) begin
        // R9: mid-frame reset clears state and raises no frame strobe
        eh = 0; ev = 0; eLs = 0; eFs = 0;
        check("R9", sH, 0); check("R9", sV, 0);
        check("R9", sFs, 0); check("R9", sHs, 1);
        rst = 1'b0;
      end else begin
        if (prevEn) modelStep(); else begin eLs = 0; eFs = 0; end
        compareSmall(prevEn);
        if (eFs) frames++;
      end
      if (resetNow) begin
        rst = 1'b1;
        pixEn = 1'b1;
      end else if (i >= 1000 && i < 1040) pixEn = 1'b0;      // long hold, R10
      else if (i >= 2000 && i < 2400)  pixEn = 1'b1;         // dense burst
      else pixEn = ($urandom % 4) != 0;
      prevEn = pixEn;
    end
    @(negedge clk);
    pixEn = 1'b0;
    check("R8", frames > 10, 1);

    // Default-size instance: enable held high, check real boundaries.
    @(negedge clk);
    fullEn = 1'b1;
    begin
      int lastLs;
      lastLs = -1;
      for (int k = 1; k <= 1700; k++) begin
        int hx;
        @(negedge clk);
        hx = k % 800;
        check("R11", fH, hx);
        check("R11", fV, k / 800);
        check("R3", fHs, !inWin(hx, 656, 96));
        check("R6", fAct, hx < 640);
        check("R7", fLs, hx == 752);
        check("R5", fVs, 1);
        if (fLs) begin
          if (lastLs >= 0) check("R11", k - lastLs, 800);
          lastLs = k;
        end
      end
    end
    fullEn = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule